// File: doc/BRIEF.md
# Serial Receiver Carrier and Lock Status Indicator

This block watches the sliced serial bit stream of a video receiver. It produces two status flags from it. The first is an active-low carrier flag. It follows raw transition activity on the line and does not care whether the data makes sense. While the carrier is absent, the block also raises a request that steers the recovery oscillator back to its centre frequency. The second flag reports lock. It rises only after a qualification time, and that time starts when a timing-reference pulse arrives with the carrier present.

When the carrier disappears while the block is locked, the lock flag drops at once. The block then opens a re-acquisition window. If a timing reference arrives in that window with the carrier back, lock returns on the next clock without a new qualification, as happens when sources are switched during blanking. If the window expires first, the block goes back to a full search. Because of this, the lock flag can pulse low while the data stays good, so downstream logic should use it only as an indicator.

All durations are parameters counted in bit clocks. The defaults are a 64-clock idle limit, 10260 clocks of qualification (about 38 µs at 270 MHz) and 2700 clocks of re-acquisition window (about 10 µs).

Top module: `carrier_lock_status`

## Requirements
- R1: The data sample taken in the first clock after reset is never counted as a transition. After that, any clock in which `sdata_i` differs from its previous sample drives `carrier_n_o` low on that clock edge, whatever the data pattern.
- R2: After `IDLE_CYCLES` consecutive clocks without a transition, `carrier_n_o` goes high on the last of those edges.
- R3: `centre_req_o` is high exactly when `carrier_n_o` is high.
- R4: While `rst_n` is low, `carrier_n_o` is 1, `lock_o` is 0 and `centre_req_o` is 1.
- R5: A `trs_i` pulse sampled while the carrier is already present starts qualification, and `lock_o` rises exactly `QUAL_CYCLES` clocks later. A `trs_i` pulse sampled while the carrier is absent has no effect.
- R6: If the carrier is lost during qualification, qualification is abandoned. A fresh `trs_i` pulse with the carrier present is then needed, followed by a full `QUAL_CYCLES` wait.
- R7: If the carrier is lost while locked, `lock_o` falls one clock after `carrier_n_o` rises. A `trs_i` pulse sampled with the carrier present less than `REACQ_CYCLES` clocks after that drop raises `lock_o` on the next clock.
- R8: If no such pulse arrives within `REACQ_CYCLES` clocks of the drop, the re-acquisition attempt ends. Lock then needs the full R5 qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata_i | input | 1 | Sliced serial data |
| trs_i | input | 1 | One-clock pulse marking a detected timing reference |
| carrier_n_o | output | 1 | Carrier flag, low while transitions are present |
| lock_o | output | 1 | Qualified lock flag |
| centre_req_o | output | 1 | Request to return the oscillator to its centre frequency |

## Verification
The assertions assume that `trs_i` is a pulse sampled on clock edges. They also assume that `sdata_i` is steady around each edge, so that every change counts as exactly one transition. The bench changes both inputs only on falling edges. It produces idle stretches by holding `sdata_i` constant, and it sends reference pulses one clock wide. The windows stay short so that both sides of every limit are reached, including pulses sent while the carrier is absent.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [1:0] {
    LQ_SEARCH = 2'd0,
    LQ_QUAL   = 2'd1,
    LQ_LOCKED = 2'd2,
    LQ_REACQ  = 2'd3
  } lq_state_e;

  // True on the clock that completes a span of len clocks.
  function automatic logic span_done(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/carrier_activity.sv
module carrier_activity
  import cls_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdata_i,
  output logic carrier_o,
  output logic edge_o
);
  localparam int unsigned CW = cnt_bits(IDLE_CYCLES);

  logic          prev_q;
  logic          prev_vld_q;
  logic [CW-1:0] idle_q;
  logic          car_q;
  logic          idle_hit;

  assign edge_o   = prev_vld_q && (sdata_i != prev_q);
  assign idle_hit = span_done(32'(idle_q), IDLE_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      idle_q     <= '0;
      car_q      <= 1'b0;
    end else begin
      prev_q     <= sdata_i;
      prev_vld_q <= 1'b1;
      if (edge_o) begin
        idle_q <= '0;
        car_q  <= 1'b1;
      end else if (idle_hit) begin
        car_q  <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign carrier_o = car_q;

  AST_EDGE_GIVES_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> carrier_o); // R1
  AST_IDLE_DROPS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && !edge_o) |=> !carrier_o); // R2

endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import cls_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES  = 10260,
  parameter int unsigned REACQ_CYCLES = 2700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  input  logic trs_i,
  output logic lock_o
);
  localparam int unsigned MAXSPAN = (QUAL_CYCLES > REACQ_CYCLES) ? QUAL_CYCLES : REACQ_CYCLES;
  localparam int unsigned CW      = cnt_bits(MAXSPAN);

  lq_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          ref_ok;
  logic          qual_hit;
  logic          window_hit;

  assign ref_ok     = carrier_i && trs_i;
  assign qual_hit   = span_done(32'(cnt_q), QUAL_CYCLES);
  assign window_hit = span_done(32'(cnt_q), REACQ_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LQ_SEARCH;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        LQ_SEARCH: if (ref_ok) begin
          st_q  <= LQ_QUAL;
          cnt_q <= '0;
        end
        LQ_QUAL: begin
          if (!carrier_i)    st_q <= LQ_SEARCH;
          else if (qual_hit) st_q <= LQ_LOCKED;
          else               cnt_q <= cnt_q + 1'b1;
        end
        LQ_LOCKED: if (!carrier_i) begin
          st_q  <= LQ_REACQ;
          cnt_q <= '0;
        end
        LQ_REACQ: begin
          if (ref_ok)          st_q <= LQ_LOCKED;
          else if (window_hit) st_q <= LQ_SEARCH;
          else                 cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= LQ_SEARCH;
      endcase
    end
  end

  assign lock_o = (st_q == LQ_LOCKED);

  AST_LOCK_ONLY_AFTER_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> (($past(st_q) == LQ_QUAL && $past(cnt_q) == CW'(QUAL_CYCLES - 1))
                    || ($past(st_q) == LQ_REACQ && $past(trs_i)))); // R5
  AST_QUAL_ABORT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LQ_QUAL && !carrier_i) |=> st_q == LQ_SEARCH); // R6
  AST_REACQ_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LQ_REACQ && window_hit && !ref_ok) |=> st_q == LQ_SEARCH); // R8

endmodule

// File: rtl/carrier_lock_status.sv
module carrier_lock_status #(
  parameter int unsigned IDLE_CYCLES  = 64,
  parameter int unsigned QUAL_CYCLES  = 10260,
  parameter int unsigned REACQ_CYCLES = 2700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdata_i,
  input  logic trs_i,
  output logic carrier_n_o,
  output logic lock_o,
  output logic centre_req_o
);
  logic carrier_w;
  logic edge_w;

  carrier_activity #(.IDLE_CYCLES(IDLE_CYCLES)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdata_i  (sdata_i),
    .carrier_o(carrier_w),
    .edge_o   (edge_w)
  );

  lock_qualifier #(.QUAL_CYCLES(QUAL_CYCLES), .REACQ_CYCLES(REACQ_CYCLES)) u_lq (
    .clk      (clk),
    .rst_n    (rst_n),
    .carrier_i(carrier_w),
    .trs_i    (trs_i),
    .lock_o   (lock_o)
  );

  assign carrier_n_o  = ~carrier_w;
  assign centre_req_o = ~carrier_w;

  AST_LOCK_FALLS_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_n_o && $past(carrier_n_o)) |-> !lock_o); // R7
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(!rst_n) |-> (carrier_n_o && !lock_o && centre_req_o)); // R4

endmodule

// File: tb/carrier_lock_status_bench.sv
module carrier_lock_status_bench;
  localparam int IDLE = 8;
  localparam int QUAL = 40;
  localparam int WIN  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic trs = 1'b0;
  logic carrier_n, lock, centre;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  carrier_lock_status #(.IDLE_CYCLES(IDLE), .QUAL_CYCLES(QUAL), .REACQ_CYCLES(WIN)) u_carrier_lock_status (
    .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .trs_i(trs),
    .carrier_n_o(carrier_n), .lock_o(lock), .centre_req_o(centre)
  );

  // behavioural reference model
  bit m_have_prev, m_prev, m_car;
  int m_quiet, m_mode, m_t0;   // mode: 0 idle search, 1 qualifying, 2 locked, 3 retry

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_have_prev = 0; m_prev = 0; m_car = 0; m_quiet = 0; m_mode = 0; m_t0 = 0;
    end else begin
      bit car_before, moved;
      car_before = m_car;
      moved = m_have_prev && (sdata != m_prev);
      m_prev = sdata; m_have_prev = 1;
      if (moved) begin m_quiet = 0; m_car = 1; end
      else begin m_quiet++; if (m_quiet >= IDLE) m_car = 0; end
      case (m_mode)
        0: if (car_before && trs) begin m_mode = 1; m_t0 = cyc; end
        1: if (!car_before) m_mode = 0; else if (cyc - m_t0 >= QUAL) m_mode = 2;
        2: if (!car_before) begin m_mode = 3; m_t0 = cyc; end
        default: if (car_before && trs) m_mode = 2; else if (cyc - m_t0 >= WIN) m_mode = 0;
      endcase
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    check("R1/R2 carrier_n", carrier_n, !m_car);
    check("R3 centre_req", centre, !m_car);
    check("R5/R6/R7/R8 lock", lock, m_mode == 2);
  endtask

  // one clock: compare the settled outputs, then drive the next inputs
  task automatic step(input logic sd, input logic t);
    @(negedge clk);
    compare_all();
    sdata = sd;
    trs = t;
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) step(~sdata, 1'b0);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(sdata, 1'b0);
  endtask

  initial begin
    sdata = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 carrier_n in reset", carrier_n, 1'b1);
    check("R4 lock in reset", lock, 1'b0);
    check("R4 centre_req in reset", centre, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    quiet(3);
    check("R1 first sample is no transition", carrier_n, 1'b1);
    step(sdata, 1'b1);               // reference with no carrier
    quiet(2);
    check("R5 reference without carrier ignored", lock, 1'b0);
    toggles(4);
    check("R1 transitions give carrier", carrier_n, 1'b0);
    // irregular pattern
    step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b0);
    check("R1 irregular data keeps carrier", carrier_n, 1'b0);
    quiet(IDLE - 1);
    check("R2 carrier held one short of idle limit", carrier_n, 1'b0);
    quiet(2);
    check("R2 carrier lost after idle limit", carrier_n, 1'b1);
    check("R3 centre request on loss", centre, 1'b1);
    // qualification aborted by carrier loss
    toggles(3);
    step(~sdata, 1'b1);
    toggles(10);
    quiet(IDLE + 2);
    toggles(QUAL + 4);
    check("R6 loss during qualification restarts", lock, 1'b0);
    // full qualification
    step(~sdata, 1'b1);
    toggles(QUAL - 1);
    check("R5 lock low before qualification ends", lock, 1'b0);
    toggles(2);
    check("R5 lock high after qualification", lock, 1'b1);
    // brief loss, fast re-acquisition
    quiet(IDLE + 2);
    check("R7 lock drops on carrier loss", lock, 1'b0);
    toggles(3);
    step(~sdata, 1'b1);
    toggles(2);
    check("R7 fast re-acquisition", lock, 1'b1);
    // loss with window expiry
    quiet(IDLE + WIN + 4);
    toggles(3);
    step(~sdata, 1'b1);
    toggles(3);
    check("R8 expired window needs full qualification", lock, 1'b0);
    toggles(QUAL);
    check("R8 lock after full qualification", lock, 1'b1);
    toggles(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule